// File: doc/BRIEF.md
# Mixed-Mode Stencil Address Generator

This block turns one access request on a 256 x 256 bit-sliced memory into a stream of element addresses. The request carries an 8-bit mode value, taken from the upper byte of the base register, and an 8-bit positioning address. A start strobe begins a sweep over element index k = 0..255. The block emits one (k, word, bit) triple per cycle, and a done flag marks the last element. The memory array, the flip network and the data path sit outside the block.

The mode works bit by bit. A mode bit at one makes the matching address bit a bit-address bit: the element index drives the bit address and the positioning address drives the word address. A mode bit at zero does the opposite. Mode 0x00 gives a bit-slice access: one bit position taken in every word. Mode 0xFF gives a word-slice access: every bit of one word. Any other mix of ones and zeros gives a stencil in between. For a mode with n ones, the stencil covers 2^n bits in each of 2^(8-n) words. Ones at the high end keep the words adjacent and spread the bits apart. Ones at the low end spread the words apart and keep the bits contiguous.

Top module: `stencil_agen`

## Requirements
- R1: After reset, valid_o and done_o are 0 and k_o is 0.
- R2: A start_i sampled high while no sweep is active starts a sweep. In the next cycle valid_o is 1 and k_o is 0.
- R3: During a sweep, k_o rises by exactly one each cycle. valid_o stays high for 256 consecutive cycles.
- R4: done_o is high only in the cycle where valid_o is 1 and k_o is 255. In the cycle after done_o, valid_o is 0.
- R5: While valid_o is 1, word_o equals (k_o AND NOT M) OR (A AND M). M and A are the mode and address captured at the accepted start.
- R6: While valid_o is 1, bit_o equals (k_o AND M) OR (A AND NOT M).
- R7: Mode 0x00 gives word_o = k_o and bit_o = A (bit slice). Mode 0xFF gives word_o = A and bit_o = k_o (word slice). Mode 0x07 with A = 0 visits words 0, 8, 16, ..., and each of those words takes bits 0..7 in turn.
- R8: A start_i that arrives during an active sweep is ignored. The sweep continues without restarting, and it keeps its captured mode and address.
- R9: Changes on mode_i and addr_i after the accepted start have no effect on the running sweep.
- R10: Over one sweep with a mode that has n ones, word_o takes exactly 2^(8-n) distinct values. Each of those values appears 2^n times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; ignored while a sweep is active |
| mode_i | input | 8 | Stencil mode (upper byte of the base register) |
| addr_i | input | 8 | Positioning address |
| valid_o | output | 1 | An element triple is present |
| k_o | output | 8 | Element index |
| word_o | output | 8 | Word address for element k |
| bit_o | output | 8 | Bit address for element k |
| done_o | output | 1 | High with the last element (k = 255) |

## Verification
Element 0 appears in the first cycle after the clock edge that samples an accepted start. Element k appears k cycles after that. done_o goes high in the cycle 256 after the start edge, and valid_o drops one cycle later. The bench drives inputs and samples outputs on the falling edge. It raises start, waits exactly one rising edge, and then checks one element on each following falling edge against functions built from R5 and R6. It checks the idle state on the falling edge after the last element. Intruding starts and input scrambling are applied between rising edges, in the middle of a sweep. Their effect is then seen at the next sample point.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
  localparam int unsigned AW_DEF = 8;
endpackage

// File: rtl/stencil_seq.sv
module stencil_seq #(
  parameter int unsigned AW = stencil_pkg::AW_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          load_o,
  output logic          valid_o,
  output logic          done_o,
  output logic [AW-1:0] k_o
);
  localparam logic [AW-1:0] K_LAST = '1;

  logic          active_q;
  logic [AW-1:0] k_q;

  assign load_o = start_i & ~active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      k_q      <= '0;
    end else if (load_o) begin
      active_q <= 1'b1;
      k_q      <= '0;
    end else if (active_q) begin
      k_q <= k_q + 1'b1;  // wraps to 0 after the last element
      if (k_q == K_LAST) active_q <= 1'b0;
    end
  end

  assign valid_o = active_q;
  assign done_o  = active_q & (k_q == K_LAST);
  assign k_o     = k_q;
endmodule

// File: rtl/stencil_cfg.sv
module stencil_cfg #(
  parameter int unsigned AW = stencil_pkg::AW_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] mode_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] mode_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] mode_q, addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      mode_q <= mode_i;
      addr_q <= addr_i;
    end
  end

  assign mode_o = mode_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/stencil_map.sv
module stencil_map #(
  parameter int unsigned AW = stencil_pkg::AW_DEF
) (
  input  logic [AW-1:0] mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] k_i,
  output logic [AW-1:0] word_o,
  output logic [AW-1:0] bit_o
);
  // mode bit high: element index steers the bit address; low: the word address
  for (genvar i = 0; i < AW; i++) begin : g_lane
    assign word_o[i] = mode_i[i] ? addr_i[i] : k_i[i];
    assign bit_o[i]  = mode_i[i] ? k_i[i]    : addr_i[i];
  end
endmodule

// File: rtl/stencil_agen.sv
module stencil_agen #(
  parameter int unsigned AW = stencil_pkg::AW_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] mode_i,
  input  logic [AW-1:0] addr_i,
  output logic          valid_o,
  output logic [AW-1:0] k_o,
  output logic [AW-1:0] word_o,
  output logic [AW-1:0] bit_o,
  output logic          done_o
);
  logic          load;
  logic [AW-1:0] k, mode_q, addr_q;

  stencil_seq #(.AW(AW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .valid_o (valid_o),
    .done_o  (done_o),
    .k_o     (k)
  );

  stencil_cfg #(.AW(AW)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .mode_i (mode_i),
    .addr_i (addr_i),
    .mode_o (mode_q),
    .addr_o (addr_q)
  );

  stencil_map #(.AW(AW)) u_map (
    .mode_i (mode_q),
    .addr_i (addr_q),
    .k_i    (k),
    .word_o (word_o),
    .bit_o  (bit_o)
  );

  assign k_o = k;
endmodule

// File: rtl/stencil_agen_chk.sv
module stencil_agen_chk #(
  parameter int unsigned AW = stencil_pkg::AW_DEF
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] mode_i,
  input logic [AW-1:0] addr_i,
  input logic          valid_o,
  input logic [AW-1:0] k_o,
  input logic [AW-1:0] word_o,
  input logic [AW-1:0] bit_o,
  input logic          done_o
);
  localparam logic [AW-1:0] K_LAST = '1;

  logic [AW-1:0] cm_q, ca_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cm_q <= '0;
      ca_q <= '0;
    end else if (start_i && !valid_o) begin
      cm_q <= mode_i;
      ca_q <= addr_i;
    end
  end

  p_start_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !valid_o |=> valid_o && k_o == '0);

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !done_o |=> valid_o && k_o == AW'($past(k_o) + 1'b1));

  p_done_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o && k_o == K_LAST);

  p_done_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !valid_o);

  p_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> word_o == ((k_o & ~cm_q) | (ca_q & cm_q)));

  p_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> bit_o == ((k_o & cm_q) | (ca_q & ~cm_q)));

  p_restart_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !done_o && start_i |=> valid_o && k_o != '0);
endmodule

bind stencil_agen stencil_agen_chk #(.AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .mode_i  (mode_i),
  .addr_i  (addr_i),
  .valid_o (valid_o),
  .k_o     (k_o),
  .word_o  (word_o),
  .bit_o   (bit_o),
  .done_o  (done_o)
);

// File: tb/sim_stencil_agen.sv
`timescale 1ns/1ps
module sim_stencil_agen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] mode_i = '0;
  logic [7:0] addr_i = '0;
  logic       valid_o, done_o;
  logic [7:0] k_o, word_o, bit_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int wcnt [256];

  always #4 clk_i = ~clk_i;  // 125 MHz

  stencil_agen u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i),
    .mode_i (mode_i), .addr_i (addr_i), .valid_o (valid_o),
    .k_o (k_o), .word_o (word_o), .bit_o (bit_o), .done_o (done_o)
  );

  function automatic logic [7:0] exp_word(logic [7:0] k, logic [7:0] m, logic [7:0] a);
    return (k & ~m) | (a & m);
  endfunction

  function automatic logic [7:0] exp_bit(logic [7:0] k, logic [7:0] m, logic [7:0] a);
    return (k & m) | (a & ~m);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // intrude: raise start again at element 'at' (R8); scramble inputs after start (R9)
  task automatic sweep(logic [7:0] m, logic [7:0] a, bit intrude, int at);
    int n;
    int distinct;
    bit cnt_ok;
    n = $countones(m);
    for (int i = 0; i < 256; i++) wcnt[i] = 0;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = m; addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0; mode_i = 8'($urandom); addr_i = 8'($urandom);
    for (int kk = 0; kk < 256; kk++) begin
      check(valid_o === 1'b1, "R2/R3 valid", int'(valid_o), 1);
      check(k_o === 8'(kk), "R3 k", int'(k_o), kk);
      check(done_o === (kk == 255), "R4 done", int'(done_o), int'(kk == 255));
      check(word_o === exp_word(8'(kk), m, a), "R5/R9 word", int'(word_o), int'(exp_word(8'(kk), m, a)));
      check(bit_o === exp_bit(8'(kk), m, a), "R6/R9 bit", int'(bit_o), int'(exp_bit(8'(kk), m, a)));
      if (m == 8'h00) begin
        check(word_o === 8'(kk) && bit_o === a, "R7 bit slice", int'(word_o), kk);
      end
      if (m == 8'hFF) begin
        check(word_o === a && bit_o === 8'(kk), "R7 word slice", int'(bit_o), kk);
      end
      if (m == 8'h07 && a == 8'h00) begin
        check(word_o === 8'((kk / 8) * 8) && bit_o === 8'(kk % 8), "R7 mode 07",
              int'(word_o), (kk / 8) * 8);
      end
      wcnt[word_o]++;
      start_i = intrude && (kk == at);
      if (intrude && kk == at) begin
        mode_i = ~m; addr_i = ~a;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    check(valid_o === 1'b0 && done_o === 1'b0, "R4 end", int'(valid_o), 0);
    distinct = 0;
    cnt_ok = 1'b1;
    for (int i = 0; i < 256; i++) begin
      if (wcnt[i] != 0) begin
        distinct++;
        if (wcnt[i] != (1 << n)) cnt_ok = 1'b0;
      end
    end
    check(distinct == (1 << (8 - n)) && cnt_ok, "R10 stencil shape", distinct, 1 << (8 - n));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check(valid_o === 1'b0 && done_o === 1'b0 && k_o === 8'h00, "R1 reset",
          int'(valid_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(valid_o === 1'b0 && k_o === 8'h00, "R1 idle", int'(valid_o), 0);

    sweep(8'h00, 8'h2A, 1'b0, 0);
    sweep(8'hFF, 8'h91, 1'b0, 0);
    sweep(8'h07, 8'h00, 1'b0, 0);
    sweep(8'hE0, 8'h5C, 1'b0, 0);
    sweep(8'h5A, 8'hC3, 1'b1, 100);  // R8 intruding start mid-sweep
    sweep(8'h3C, 8'h11, 1'b1, 254);  // R8 intruding start near the end
    sweep(8'h81, 8'hFF, 1'b1, 0);    // R8 intruding start on element 0
    for (int r = 0; r < 12; r++) begin
      sweep(8'($urandom), 8'($urandom), bit'($urandom % 2), int'($urandom % 255));
    end
    // idle gaps between sweeps: no start, nothing happens
    repeat (5) begin
      @(negedge clk_i);
      check(valid_o === 1'b0, "R2 no spurious start", int'(valid_o), 0);
    end
    finish_run();
  end
endmodule